// File: doc/BRIEF.md
# Dithered PWM Output Driver

This block drives one output pin from a 15-bit brightness level. The level is split into an 8-bit base duty and a 7-bit fraction. The base duty drives a phase-correct (triangle) compare PWM with 256 duty steps. A first-order carry accumulator spreads the fraction over successive periods: each period runs at either the base duty or the base duty plus one. Averaged over 128 periods, the duty gains seven bits of resolution beyond the plain compare.

The level input is watched continuously. Any change of its saturated value counts as a new write. A write applies the new base duty at once. Otherwise the applied duty changes only at the bottom of the triangle counter, so a period never sees a mid-period compare change. A modulation enable gates the pin and freezes the dither state. A phase-reset request restarts the triangle from zero.

Top module: `dither_pwm`

## Requirements
- R1: The level is split into a base duty (bits 14:7) and a fraction (bits 6:0). After a level change, `duty_o` shows the base duty one clock later.
- R2: An internal 8-bit counter runs 0,1,...,255,254,...,1,0 and repeats, so one period lasts 510 clocks. `period_o` is high exactly in the cycles where the counter is 0, including the first cycle after reset.
- R3: `pwm_o` is high when the enable is high and the counter is below the applied duty. A duty of d>0 gives 2d-1 high cycles per period, and a duty of 0 gives none.
- R4: When the level does not change, `duty_o` changes only on the clock edge that ends a `period_o` cycle.
- R5: At each period bottom with enable high, the fraction is added to a 7-bit accumulator. The period that follows uses the previously computed next duty. Over any 128 consecutive periods, exactly `fraction` of them run at base+1 and the rest at base.
- R6: The next duty is base+1 when accumulator plus fraction exceeds 127, and base otherwise. The accumulator then keeps only its low 7 bits. With a fraction of 64, the two duties alternate.
- R7: A level change sets both the applied duty and the next duty to the new base duty in the same clock edge. This takes priority over a bottom update, and the accumulator is kept.
- R8: With the enable low, `pwm_o` stays low, and the applied duty, next duty and accumulator hold.
- R9: A phase-reset request puts the counter at 0, counting up, on the next clock. `period_o` is then high, and the next bottom follows 510 clocks later. The accumulator is not cleared.
- R10: A level above 32640 (255 shifted left by 7) is treated as 32640, so the duty is 255 with no carry.
- R11: During and right after reset, `duty_o` is 0 and `pwm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 15 | Brightness level, base in 14:7, fraction in 6:0 |
| mod_en_i | input | 1 | Modulation enable; low holds the pin off |
| phase_rst_i | input | 1 | Restart the triangle counter at 0 |
| pwm_o | output | 1 | PWM pin |
| period_o | output | 1 | High while the counter is at its bottom |
| duty_o | output | 8 | Currently applied duty |

## Verification
A level change is visible on `duty_o` one clock after it is applied. `pwm_o` is combinational from the enable and from registers, so it follows the enable in the same cycle and the counter with no extra delay. A dither result reaches `duty_o` only on the edge after a `period_o` cycle, one period after the accumulator produced it. The bench's reference model advances on each rising edge from the same inputs, and the bench compares all three outputs at every falling edge, so every due cycle is sampled exactly. The directed checks count over whole periods aligned to `period_o` (high-cycle counts, 510-cycle spacing, carries in 128 and 32 consecutive periods), so the pipeline delay of the next-duty register cannot shift a count.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned DUTY_W_DEF = 8;
  localparam int unsigned FRAC_W_DEF = 7;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/dpwm_tri_cnt.sv
module dpwm_tri_cnt
  import dpwm_pkg::*;
#(
  parameter int unsigned CNT_W = DUTY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bottom_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (phase_rst_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q == CNT_MAX) begin
        dir_q <= DIR_DOWN;
        cnt_q <= CNT_MAX - CNT_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      if (cnt_q == '0) begin
        dir_q <= DIR_UP;
        cnt_q <= CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign bottom_o = (cnt_q == '0);

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_rst_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
                     (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9
  phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_i |=> (cnt_q == '0) && (dir_q == DIR_UP));
endmodule

// File: rtl/dpwm_level.sv
module dpwm_level
  import dpwm_pkg::*;
#(
  parameter int unsigned DUTY_W = DUTY_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DUTY_W+FRAC_W-1:0] level_i,
  output logic [DUTY_W-1:0]        base_o,
  output logic [FRAC_W-1:0]        frac_o,
  output logic                     wr_o
);
  localparam int unsigned LVL_W = DUTY_W + FRAC_W;
  localparam logic [LVL_W-1:0] LVL_MAX = {{DUTY_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [LVL_W-1:0] lvl_sat;
  logic [LVL_W-1:0] lvl_q;

  assign lvl_sat = (level_i > LVL_MAX) ? LVL_MAX : level_i;
  assign wr_o    = (lvl_sat != lvl_q);
  assign base_o  = lvl_sat[LVL_W-1:FRAC_W];
  assign frac_o  = lvl_sat[FRAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_sat;
  end

  // R10
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o == {DUTY_W{1'b1}}) |-> (frac_o == '0));
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
  import dpwm_pkg::*;
#(
  parameter int unsigned DUTY_W = DUTY_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bottom_i,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] base_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [DUTY_W-1:0] duty_o
);
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] nxt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      nxt_q  <= '0;
      acc_q  <= '0;
    end else if (wr_i) begin
      duty_q <= base_i;
      nxt_q  <= base_i;
    end else if (bottom_i && en_i) begin
      // load first, then compute the value for the following period
      duty_q <= nxt_q;
      nxt_q  <= base_i + DUTY_W'(sum[FRAC_W]);
      acc_q  <= sum[FRAC_W-1:0];
    end
  end

  assign duty_o = duty_q;

  // R4
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bottom_i && !wr_i) |=> $stable(duty_q));

  // R7
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (duty_q == $past(base_i)) && (nxt_q == $past(base_i)) && $stable(acc_q));

  // R6
  nxt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (nxt_q == base_i) || (nxt_q == base_i + DUTY_W'(1)));

  // R8
  en_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(duty_q) && $stable(nxt_q) && $stable(acc_q));
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned DUTY_W = DUTY_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DUTY_W+FRAC_W-1:0] level_i,
  input  logic                     mod_en_i,
  input  logic                     phase_rst_i,
  output logic                     pwm_o,
  output logic                     period_o,
  output logic [DUTY_W-1:0]        duty_o
);
  logic [DUTY_W-1:0] cnt;
  logic              bottom;
  logic [DUTY_W-1:0] base;
  logic [FRAC_W-1:0] frac;
  logic              wr;
  logic [DUTY_W-1:0] duty;

  dpwm_tri_cnt #(.CNT_W(DUTY_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_rst_i(phase_rst_i),
    .cnt_o      (cnt),
    .bottom_o   (bottom)
  );

  dpwm_level #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_i),
    .base_o (base),
    .frac_o (frac),
    .wr_o   (wr)
  );

  dpwm_dither #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_dith (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mod_en_i),
    .bottom_i(bottom),
    .wr_i    (wr),
    .base_i  (base),
    .frac_i  (frac),
    .duty_o  (duty)
  );

  // non-inverted: high below compare
  assign pwm_o    = mod_en_i && (cnt < duty);
  assign period_o = bottom;
  assign duty_o   = duty;

  // R3
  full_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o == '0) |-> !pwm_o);
endmodule

// File: tb/sim_dither_pwm.sv
`timescale 1ns/1ps
module sim_dither_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] level = '0;
  logic        en = 1'b0;
  logic        prst = 1'b0;
  logic        pwm;
  logic        per;
  logic [7:0]  duty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_cnt = 0, m_up = 1, m_duty = 0, m_nxt = 0, m_acc = 0, m_lvl = 0;

  always #4 clk = ~clk;

  dither_pwm u0 (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .mod_en_i(en),
    .phase_rst_i(prst), .pwm_o(pwm), .period_o(per), .duty_o(duty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_duty = 0; m_nxt = 0; m_acc = 0; m_lvl = 0;
    end else begin
      int sat, b, f, s;
      bit bot;
      sat = (int'(level) > 32640) ? 32640 : int'(level);
      b = sat / 128;
      f = sat % 128;
      bot = (m_cnt == 0);
      if (sat != m_lvl) begin
        m_duty = b; m_nxt = b;
      end else if (bot && en) begin
        m_duty = m_nxt;
        s = m_acc + f;
        m_nxt = b + ((s > 127) ? 1 : 0);
        m_acc = s % 128;
      end
      m_lvl = sat;
      if (prst) begin
        m_cnt = 0; m_up = 1;
      end else if (m_up == 1) begin
        if (m_cnt == 255) begin m_up = 0; m_cnt = 254; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
        else m_cnt = m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 pwm_o model", int'(pwm), (en && (m_cnt < m_duty)) ? 1 : 0);
      chk("R2 period_o model", int'(per), (m_cnt == 0) ? 1 : 0);
      chk("R4 duty_o model", int'(duty), m_duty);
    end
  end

  task automatic wait_bottom();
    do @(negedge clk); while (!per);
  endtask

  task automatic high_count(output int h);
    wait_bottom();
    h = 0;
    repeat (510) begin
      if (pwm) h++;
      @(negedge clk);
    end
  endtask

  task automatic spacing(output int n);
    wait_bottom();
    n = 0;
    do begin @(negedge clk); n++; end while (!per);
  endtask

  initial begin
    int h, n, c;
    int d0;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 reset duty_o", int'(duty), 0);
    chk("R11 reset pwm_o", int'(pwm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 post-reset duty_o", int'(duty), 0);

    en = 1'b1;
    level = 15'(100 * 128);
    @(negedge clk);
    chk("R1 base split", int'(duty), 100);
    chk("R7 immediate duty", int'(duty), 100);
    high_count(h);
    chk("R3 high count d=100", h, 199);
    spacing(n);
    chk("R2 period length", n, 510);

    level = 15'd0;
    @(negedge clk);
    high_count(h);
    chk("R3 high count d=0", h, 0);

    level = 15'(255 * 128);
    @(negedge clk);
    high_count(h);
    chk("R3 high count d=255", h, 509);

    level = 15'h7FFF;
    @(negedge clk);
    chk("R10 saturated duty", int'(duty), 255);
    c = 0;
    for (int i = 0; i < 4; i++) begin
      wait_bottom();
      if (duty != 8'd255) c++;
    end
    chk("R10 no carry beyond 255", c, 0);

    level = 15'(50 * 128 + 37);
    @(negedge clk);
    chk("R7 write with fraction", int'(duty), 50);
    wait_bottom(); wait_bottom();
    c = 0;
    for (int i = 0; i < 128; i++) begin
      wait_bottom();
      if (duty == 8'd51) c++;
      else if (duty != 8'd50) c += 1000;
    end
    chk("R5 carries in 128 periods", c, 37);

    level = 15'(20 * 128 + 64);
    @(negedge clk);
    wait_bottom(); wait_bottom();
    c = 0;
    for (int i = 0; i < 32; i++) begin
      wait_bottom();
      if (duty == 8'd21) c++;
    end
    chk("R6 alternation frac=64", c, 16);

    // R8: enable low
    level = 15'(80 * 128 + 5);
    @(negedge clk);
    en = 1'b0;
    d0 = int'(duty);
    high_count(h);
    chk("R8 pin off when disabled", h, 0);
    wait_bottom(); wait_bottom();
    chk("R8 duty held", int'(duty), d0);
    en = 1'b1;

    // R9: phase reset mid-period
    wait_bottom();
    repeat (77) @(negedge clk);
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
    chk("R9 bottom after phase reset", int'(per), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!per);
    chk("R9 spacing after phase reset", n, 510);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule